// File: doc/BRIEF.md
# Accumulator Machine Execution Core

This block is a compact multicycle processor built around a single 8-bit accumulator and one index register. It takes its instructions from a unified, word-addressed memory, one 16-bit word per instruction. The opcode sits in the upper byte and the operand in the lower byte. Data words use only the lower byte of a memory word. Memory is outside the core and is reached through a synchronous port: an address presented in one cycle returns its read data one cycle later, and a write is a one-cycle strobe.

The instruction set covers data movement (immediate, direct and indexed loads; index loads and copies; stores), arithmetic (add from memory or immediate, subtract immediate, increment of either register), bitwise logic and logical shifts, equality compares against an immediate or through a pointer held in memory, and absolute jumps. Two of the jumps depend on a single compare flag. A character output strobe and a halt instruction complete the set. Any opcode outside the set stops the core and raises an error flag.

Each instruction takes 4 cycles when it needs no data access. It takes 5 cycles with one data read (direct or indexed) and 7 cycles for the indirect compare, which reads a pointer first and then the data it names.

Top module: `acc_core`

## Requirements
- R1: After reset is released, the first fetch reads address 0. The accumulator, the index register and the compare flag are 0, and halted, error, out_valid and mem_we are low.
- R2: An instruction word is {opcode[15:8], operand[7:0]}. Opcodes (hex): 01 load immediate, 02 load direct, 03 load indexed, 04 load index immediate, 05 copy ACC to IX, 06 store, 07 add memory, 08 add immediate, 09 subtract immediate, 0A increment ACC, 0B increment IX, 0C jump, 0D compare immediate, 0E compare indirect, 0F jump if equal, 10 jump if not equal, 11/12 AND immediate/memory, 13/14 OR immediate/memory, 15/16 XOR immediate/memory, 17 shift left, 18 shift right, 19 output, 1A halt.
- R3: Load immediate places the operand in ACC, and load direct places the low byte of memory[operand] in ACC. Load indexed reads memory[(operand + IX) mod 256].
- R4: Add (memory or immediate), subtract immediate and increment ACC all wrap modulo 256.
- R5: AND, OR and XOR combine ACC with either the operand or the low byte of memory[operand].
- R6: The shift instructions move ACC by the operand count with zero fill. A count of 8 or more yields 0.
- R7: Load index immediate sets IX to the operand, copy sets IX to ACC, and increment IX adds 1 modulo 256.
- R8: A store writes {8'h00, ACC} to memory[operand] with mem_we high for exactly one cycle.
- R9: Compare immediate sets the flag to (ACC == operand). Compare indirect sets it to (ACC == memory[memory[operand]]). No other instruction changes the flag.
- R10: The unconditional jump always loads PC from the operand. Jump-if-equal jumps only when the flag is 1, and jump-if-not-equal jumps only when it is 0. Otherwise execution continues at the next word.
- R11: The output instruction raises out_valid for exactly one cycle, with out_char equal to ACC.
- R12: The halt instruction sets halted, which stays set until reset. While halted, no write, no output strobe and no address change occur, and error stays low.
- R13: An opcode outside the R2 list sets both halted and error and executes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Registered memory word address |
| mem_we | output | 1 | Registered one-cycle write strobe |
| mem_wdata | output | 16 | Write word, upper byte zero |
| mem_rdata | input | 16 | Read word, valid one cycle after the address |
| out_valid | output | 1 | One-cycle character strobe |
| out_char | output | 8 | Character code emitted |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Stop was caused by an undefined opcode |

## Verification
The checker assumes that memory behaves as a single-port synchronous RAM: read data appears exactly one cycle after the address, and a write takes effect on the edge where mem_we is sampled high. The bench memory model is built that way. It is loaded only while reset is held, so stimulus never races the core's own accesses. The checks also assume that reset is held for at least one edge before each program runs. Every program ends in a halt or an undefined opcode within a few hundred cycles, so the halted-state properties are exercised in every run.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_LDI  = 8'h01;
  localparam logic [OPC_W-1:0] OP_LDD  = 8'h02;
  localparam logic [OPC_W-1:0] OP_LDX  = 8'h03;
  localparam logic [OPC_W-1:0] OP_IXI  = 8'h04;
  localparam logic [OPC_W-1:0] OP_CPX  = 8'h05;
  localparam logic [OPC_W-1:0] OP_STO  = 8'h06;
  localparam logic [OPC_W-1:0] OP_ADM  = 8'h07;
  localparam logic [OPC_W-1:0] OP_ADI  = 8'h08;
  localparam logic [OPC_W-1:0] OP_SBI  = 8'h09;
  localparam logic [OPC_W-1:0] OP_INA  = 8'h0A;
  localparam logic [OPC_W-1:0] OP_INX  = 8'h0B;
  localparam logic [OPC_W-1:0] OP_JMP  = 8'h0C;
  localparam logic [OPC_W-1:0] OP_CPI  = 8'h0D;
  localparam logic [OPC_W-1:0] OP_CPN  = 8'h0E;
  localparam logic [OPC_W-1:0] OP_JEQ  = 8'h0F;
  localparam logic [OPC_W-1:0] OP_JNE  = 8'h10;
  localparam logic [OPC_W-1:0] OP_ANI  = 8'h11;
  localparam logic [OPC_W-1:0] OP_ANM  = 8'h12;
  localparam logic [OPC_W-1:0] OP_ORI  = 8'h13;
  localparam logic [OPC_W-1:0] OP_ORM  = 8'h14;
  localparam logic [OPC_W-1:0] OP_XRI  = 8'h15;
  localparam logic [OPC_W-1:0] OP_XRM  = 8'h16;
  localparam logic [OPC_W-1:0] OP_SHL  = 8'h17;
  localparam logic [OPC_W-1:0] OP_SHR  = 8'h18;
  localparam logic [OPC_W-1:0] OP_PUT  = 8'h19;
  localparam logic [OPC_W-1:0] OP_STOP = 8'h1A;

  typedef enum logic [1:0] {AM_NONE, AM_DIRECT, AM_INDEXED, AM_INDIRECT} amode_t;

  typedef enum logic [3:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SHL, ALU_SHR, ALU_INC
  } alu_op_t;

  typedef enum logic [1:0] {IX_KEEP, IX_IMM, IX_ACC, IX_INC} ix_op_t;

  typedef enum logic [1:0] {BR_NEVER, BR_ALWAYS, BR_EQ, BR_NE} br_t;

  typedef struct packed {
    logic    legal;
    amode_t  amode;
    alu_op_t alu;
    logic    acc_wr;
    ix_op_t  ix_op;
    logic    store;
    logic    cmp;
    br_t     br;
    logic    put;
    logic    stop;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_FWAIT, ST_DECODE, ST_PWAIT, ST_PTR, ST_DWAIT, ST_EXEC, ST_HALT
  } state_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctl
);

  always_comb begin
    ctl       = '0;
    ctl.legal = 1'b1;
    unique case (opc)
      OP_LDI:  begin ctl.alu = ALU_PASS; ctl.acc_wr = 1'b1; end
      OP_LDD:  begin ctl.amode = AM_DIRECT;  ctl.alu = ALU_PASS; ctl.acc_wr = 1'b1; end
      OP_LDX:  begin ctl.amode = AM_INDEXED; ctl.alu = ALU_PASS; ctl.acc_wr = 1'b1; end
      OP_IXI:  ctl.ix_op = IX_IMM;
      OP_CPX:  ctl.ix_op = IX_ACC;
      OP_STO:  ctl.store = 1'b1;
      OP_ADM:  begin ctl.amode = AM_DIRECT; ctl.alu = ALU_ADD; ctl.acc_wr = 1'b1; end
      OP_ADI:  begin ctl.alu = ALU_ADD; ctl.acc_wr = 1'b1; end
      OP_SBI:  begin ctl.alu = ALU_SUB; ctl.acc_wr = 1'b1; end
      OP_INA:  begin ctl.alu = ALU_INC; ctl.acc_wr = 1'b1; end
      OP_INX:  ctl.ix_op = IX_INC;
      OP_JMP:  ctl.br = BR_ALWAYS;
      OP_CPI:  ctl.cmp = 1'b1;
      OP_CPN:  begin ctl.amode = AM_INDIRECT; ctl.cmp = 1'b1; end
      OP_JEQ:  ctl.br = BR_EQ;
      OP_JNE:  ctl.br = BR_NE;
      OP_ANI:  begin ctl.alu = ALU_AND; ctl.acc_wr = 1'b1; end
      OP_ANM:  begin ctl.amode = AM_DIRECT; ctl.alu = ALU_AND; ctl.acc_wr = 1'b1; end
      OP_ORI:  begin ctl.alu = ALU_OR; ctl.acc_wr = 1'b1; end
      OP_ORM:  begin ctl.amode = AM_DIRECT; ctl.alu = ALU_OR; ctl.acc_wr = 1'b1; end
      OP_XRI:  begin ctl.alu = ALU_XOR; ctl.acc_wr = 1'b1; end
      OP_XRM:  begin ctl.amode = AM_DIRECT; ctl.alu = ALU_XOR; ctl.acc_wr = 1'b1; end
      OP_SHL:  begin ctl.alu = ALU_SHL; ctl.acc_wr = 1'b1; end
      OP_SHR:  begin ctl.alu = ALU_SHR; ctl.acc_wr = 1'b1; end
      OP_PUT:  ctl.put = 1'b1;
      OP_STOP: ctl.stop = 1'b1;
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_t      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int SH_W = $clog2(W);

  logic             big_shift;
  logic [SH_W-1:0]  sh_amt;

  // counts of W or more clear the result (R6)
  assign big_shift = |b[W-1:SH_W];
  assign sh_amt    = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SHL: y = big_shift ? '0 : (a << sh_amt);
      ALU_SHR: y = big_shift ? '0 : (a >> sh_amt);
      ALU_INC: y = a + W'(1);
      default: y = b;
    endcase
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [DATA_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic [OPC_W+DATA_W-1:0] mem_wdata,
  input  logic [OPC_W+DATA_W-1:0] mem_rdata,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_char,
  output logic                    halted,
  output logic                    error
);

  localparam int IW = OPC_W + DATA_W;

  state_t             state;
  logic [DATA_W-1:0]  pc, acc, ix;
  logic [IW-1:0]      ir;
  logic               eq_flag;

  logic [OPC_W-1:0]   dec_opc;
  ctrl_t              ctl;
  logic [DATA_W-1:0]  ir_opnd, rd_opnd, rd_data, bval, alu_y;
  logic               br_taken;

  // one decoder: raw word while decoding, held word afterwards
  assign dec_opc = (state == ST_DECODE) ? mem_rdata[IW-1:DATA_W] : ir[IW-1:DATA_W];
  assign ir_opnd = ir[DATA_W-1:0];
  assign rd_opnd = mem_rdata[DATA_W-1:0];
  assign rd_data = mem_rdata[DATA_W-1:0];
  assign bval    = (ctl.amode == AM_NONE) ? ir_opnd : rd_data;

  acc_decode u_dec (
    .opc (dec_opc),
    .ctl (ctl)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op (ctl.alu),
    .a  (acc),
    .b  (bval),
    .y  (alu_y)
  );

  always_comb begin
    unique case (ctl.br)
      BR_ALWAYS: br_taken = 1'b1;
      BR_EQ:     br_taken = eq_flag;
      BR_NE:     br_taken = ~eq_flag;
      default:   br_taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FETCH;
      pc        <= '0;
      acc       <= '0;
      ix        <= '0;
      ir        <= '0;
      eq_flag   <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      out_valid <= 1'b0;
      out_char  <= '0;
      halted    <= 1'b0;
      error     <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      out_valid <= 1'b0;
      unique case (state)
        ST_FETCH: begin
          mem_addr <= pc;
          state    <= ST_FWAIT;
        end
        ST_FWAIT: state <= ST_DECODE;
        ST_DECODE: begin
          ir <= mem_rdata;
          pc <= pc + DATA_W'(1);
          if (!ctl.legal) begin
            halted <= 1'b1;
            error  <= 1'b1;
            state  <= ST_HALT;
          end else begin
            unique case (ctl.amode)
              AM_DIRECT: begin
                mem_addr <= rd_opnd;
                state    <= ST_DWAIT;
              end
              AM_INDEXED: begin
                mem_addr <= rd_opnd + ix;
                state    <= ST_DWAIT;
              end
              AM_INDIRECT: begin
                mem_addr <= rd_opnd;
                state    <= ST_PWAIT;
              end
              default: state <= ST_EXEC;
            endcase
          end
        end
        ST_PWAIT: state <= ST_PTR;
        ST_PTR: begin
          mem_addr <= rd_data;
          state    <= ST_DWAIT;
        end
        ST_DWAIT: state <= ST_EXEC;
        ST_EXEC: begin
          state <= ST_FETCH;
          if (ctl.acc_wr) acc <= alu_y;
          unique case (ctl.ix_op)
            IX_IMM:  ix <= ir_opnd;
            IX_ACC:  ix <= acc;
            IX_INC:  ix <= ix + DATA_W'(1);
            default: ix <= ix;
          endcase
          if (ctl.cmp) eq_flag <= (acc == bval);
          if (ctl.store) begin
            mem_addr  <= ir_opnd;
            mem_wdata <= {{OPC_W{1'b0}}, acc};
            mem_we    <= 1'b1;
          end
          if (ctl.put) begin
            out_valid <= 1'b1;
            out_char  <= acc;
          end
          if (br_taken) pc <= ir_opnd;
          if (ctl.stop) begin
            halted <= 1'b1;
            state  <= ST_HALT;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 8,
  parameter int IW     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [IW-1:0]     mem_wdata,
  input logic              out_valid,
  input logic              halted,
  input logic              error
);

  // R8: one-cycle write strobe, upper byte of the stored word is zero
  p_we_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  p_wdata_upper_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[IW-1:DATA_W] == '0));

  // R11: one-cycle output strobe
  p_out_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R12: halt is sticky and quiet
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    halted |=> (!mem_we && !out_valid && $stable(mem_addr)));

  // R13: error only together with halt
  p_err_halt_r13: assert property (@(posedge clk) disable iff (rst)
    error |-> halted);
  p_err_sticky_r13: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .IW(OPC_W + DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .out_valid (out_valid),
  .halted    (halted),
  .error     (error)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        out_valid;
  logic [7:0]  out_char;
  logic        halted;
  logic        error;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        cap_clr = 1'b1;

  logic [15:0] mem [256];
  logic [7:0]  cap [16];
  int          cap_n, we_n, dbl_n;
  logic        prev_ov;
  int          nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_char(out_char), .halted(halted), .error(error)
  );

  // synchronous single-port memory, loaded only while reset is held
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (cap_clr) begin
      cap_n <= 0; we_n <= 0; dbl_n <= 0; prev_ov <= 1'b0;
    end else begin
      prev_ov <= out_valid;
      if (out_valid && prev_ov) dbl_n <= dbl_n + 1;
      if (mem_we) we_n <= we_n + 1;
      if (out_valid && cap_n < 16) begin
        cap[cap_n] <= out_char;
        cap_n <= cap_n + 1;
      end
    end
  end

  // each row: {req, initial ACC, opcode, operand, expected output}
  localparam logic [39:0] VEC [16] = '{
    {8'd3, 8'h00, 8'h01, 8'h37, 8'h37},  // R3 immediate load
    {8'd3, 8'h00, 8'h02, 8'h40, 8'h5A},  // R3 direct load
    {8'd3, 8'h00, 8'h03, 8'h40, 8'h5A},  // R3 indexed load, IX = 0
    {8'd4, 8'h10, 8'h07, 8'h40, 8'h6A},  // R4 add memory
    {8'd4, 8'hF0, 8'h08, 8'h20, 8'h10},  // R4 add immediate wraps
    {8'd4, 8'h05, 8'h09, 8'h07, 8'hFE},  // R4 subtract wraps
    {8'd4, 8'hFF, 8'h0A, 8'h00, 8'h00},  // R4 increment wraps
    {8'd5, 8'hB7, 8'h11, 8'h4C, 8'h04},  // R5 AND immediate
    {8'd5, 8'hF0, 8'h12, 8'h40, 8'h50},  // R5 AND memory
    {8'd5, 8'h90, 8'h13, 8'h4F, 8'hDF},  // R5 OR immediate
    {8'd5, 8'h01, 8'h14, 8'h40, 8'h5B},  // R5 OR memory
    {8'd5, 8'hFF, 8'h15, 8'h0F, 8'hF0},  // R5 XOR immediate
    {8'd5, 8'h5A, 8'h16, 8'h40, 8'h00},  // R5 XOR memory
    {8'd6, 8'h81, 8'h17, 8'h01, 8'h02},  // R6 shift left
    {8'd6, 8'hB4, 8'h18, 8'h02, 8'h2D},  // R6 shift right
    {8'd6, 8'hFF, 8'h18, 8'h09, 8'h00}   // R6 oversized count
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_data = d;
  endtask

  task automatic begin_prog();
    rst = 1'b1; cap_clr = 1'b1;
    for (int a = 0; a < 256; a++) poke(a, 16'h0000);
    poke(8'h40, 16'h005A);
    poke(8'h41, 16'h0040);
    poke(8'h42, 16'h0033);
    poke(8'h43, 16'h0077);
  endtask

  task automatic run_prog();
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk); cap_clr = 1'b0; rst = 1'b0;
    for (int c = 0; c < 3000 && !halted; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog: actual=running expected=halted");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: outputs under reset
    repeat (2) @(negedge clk);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 error", 32'(error), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 mem_addr", 32'(mem_addr), 0);

    // R1: start at 0 with flag 0 and IX 0
    begin_prog();
    poke(0, 16'h0F03); poke(1, 16'h0340); poke(2, 16'h1900); poke(3, 16'h1A00);
    run_prog();
    chk("R1 count", cap_n, 1);
    chk("R1 char", 32'(cap[0]), 32'h5A);

    // R2/R3..R6 vector table
    for (int i = 0; i < 16; i++) begin
      begin_prog();
      poke(0, {8'h01, VEC[i][31:24]});
      poke(1, VEC[i][23:8]);
      poke(2, 16'h1900);
      poke(3, 16'h1A00);
      run_prog();
      chk($sformatf("R2 R%0d vec %0d count", VEC[i][39:32], i), cap_n, 1);
      chk($sformatf("R2 R%0d vec %0d value", VEC[i][39:32], i), 32'(cap[0]), 32'(VEC[i][7:0]));
      chk($sformatf("R2 R%0d vec %0d error", VEC[i][39:32], i), 32'(error), 0);
    end

    // R7 and R3: index register handling and indexed wrap
    begin_prog();
    poke(0, 16'h0401); poke(1, 16'h0340); poke(2, 16'h1900);
    poke(3, 16'h0102); poke(4, 16'h0500); poke(5, 16'h0340); poke(6, 16'h1900);
    poke(7, 16'h0B00); poke(8, 16'h0340); poke(9, 16'h1900);
    poke(10, 16'h040C); poke(11, 16'h03FF); poke(12, 16'h1900); poke(13, 16'h1A00);
    run_prog();
    chk("R7 count", cap_n, 4);
    chk("R7 load index", 32'(cap[0]), 32'h40);
    chk("R7 copy", 32'(cap[1]), 32'h33);
    chk("R7 increment", 32'(cap[2]), 32'h77);
    chk("R3 index wrap", 32'(cap[3]), 32'hFF);

    // R8: store then reload
    begin_prog();
    poke(0, 16'h0166); poke(1, 16'h0650); poke(2, 16'h0100);
    poke(3, 16'h0250); poke(4, 16'h1900); poke(5, 16'h1A00);
    run_prog();
    chk("R8 memory word", 32'(mem[8'h50]), 32'h0066);
    chk("R8 reload", 32'(cap[0]), 32'h66);
    chk("R8 strobes", we_n, 1);

    // R9/R10: compare flag and jumps
    begin_prog();
    poke(0, 16'h0105); poke(1, 16'h0D05); poke(2, 16'h0F04); poke(3, 16'h1A00);
    poke(4, 16'h0141); poke(5, 16'h1900); poke(6, 16'h0105); poke(7, 16'h1009);
    poke(8, 16'h0F0A); poke(9, 16'h1A00); poke(10, 16'h0D06); poke(11, 16'h100D);
    poke(12, 16'h1A00); poke(13, 16'h0142); poke(14, 16'h1900); poke(15, 16'h0C11);
    poke(16, 16'h1A00); poke(17, 16'h0143); poke(18, 16'h1900); poke(19, 16'h1A00);
    run_prog();
    chk("R10 count", cap_n, 3);
    chk("R9 flag held", 32'(cap[1]), 32'h42);
    chk("R10 path", 32'(cap[2]), 32'h43);
    chk("R11 single cycle", dbl_n, 0);

    // R9: indirect compare equal and not equal
    begin_prog();
    poke(0, 16'h015A); poke(1, 16'h0E41); poke(2, 16'h0F04); poke(3, 16'h1A00);
    poke(4, 16'h0143); poke(5, 16'h1900); poke(6, 16'h0111); poke(7, 16'h0E41);
    poke(8, 16'h100A); poke(9, 16'h1A00); poke(10, 16'h0144); poke(11, 16'h1900);
    poke(12, 16'h1A00);
    run_prog();
    chk("R9 indirect count", cap_n, 2);
    chk("R9 indirect equal", 32'(cap[0]), 32'h43);
    chk("R9 indirect differ", 32'(cap[1]), 32'h44);

    // R12: halt stops everything
    begin_prog();
    poke(0, 16'h0145); poke(1, 16'h1900); poke(2, 16'h1A00); poke(3, 16'h1900);
    run_prog();
    repeat (20) @(negedge clk);
    #1;
    chk("R12 halted", 32'(halted), 1);
    chk("R12 error", 32'(error), 0);
    chk("R12 no further output", cap_n, 1);
    chk("R11 char", 32'(cap[0]), 32'h45);

    // R13: undefined opcode
    begin_prog();
    poke(0, 16'hFF00); poke(1, 16'h1900); poke(2, 16'h1A00);
    run_prog();
    chk("R13 halted", 32'(halted), 1);
    chk("R13 error", 32'(error), 1);
    chk("R13 nothing executed", cap_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule